// File: doc/BRIEF.md
# Masked BCD Time Alarm Matcher

This block compares the live time and date fields (seconds, minutes, hours, day of week, day of month, month) against six alarm registers. Each alarm register pairs a BCD compare value with its own enable bit. On every one-second tick the block checks the enabled fields. When at least one field is enabled and every enabled field equals its counter, the block raises a sticky alarm flag. The interrupt request is that flag gated by an interrupt-enable bit.

Software programs the alarm registers and a small control register through a write port and a registered read port. The calendar counters and the tick come from the clock logic beside this block. They are presented already updated in the cycle where the tick is high. A match that lasts across several ticks raises the flag only once, when the match begins. An alarm on the minute alone therefore fires once, not sixty times. A synchronous reset acts as the power-on reset: it clears every enable bit and the flag but keeps all compare values.

Top module: `alm_matcher`

## Requirements
- R1: Addresses 0 to 5 hold the second, minute, hour, day-of-week, day and month alarms. In each, bit 7 is the enable bit and bits [W-1:0] hold the compare value, with W = 7, 7, 6, 3, 6, 5 in that order. Bits between W and 6 read as 0. Read data appears on `rd_data` one clock after `rd_addr` is presented.
- R2: Reset clears every alarm enable bit, the interrupt enable and the alarm flag. The compare values keep their contents through reset.
- R3: A field whose enable bit is 0 takes no part in the match, whatever its counter holds.
- R4: On a cycle with `tick` high, the flag is set when at least one field is enabled and every enabled field equals its counter input.
- R5: With no enable bit set, the flag is never set.
- R6: A match on consecutive ticks sets the flag only on the first of them. A tick without a match re-arms detection. The first tick after reset counts as following a non-match.
- R7: The flag stays set until a write to address 6 with bit 1 set. When a new match and a clear fall in the same cycle, the flag ends up set.
- R8: Address 6 holds the interrupt enable in bit 0 (read/write) and returns the flag in bit 1. `irq` is a register equal to flag AND interrupt enable, updated on the same edge as both.
- R9: Counter inputs are only evaluated in cycles where `tick` is high. A match present between ticks does not set the flag.
- R10: Address 7 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| cnt_sec | input | 7 | Current seconds, BCD |
| cnt_min | input | 7 | Current minutes, BCD |
| cnt_hour | input | 6 | Current hours, BCD |
| cnt_wday | input | 3 | Current day of week |
| cnt_day | input | 6 | Current day of month, BCD |
| cnt_mon | input | 5 | Current month, BCD |
| tick | input | 1 | One-second tick; counters are valid and updated in this cycle |
| irq | output | 1 | Alarm interrupt request |

## Verification
The assertions assume that `tick` comes only with counter values that have settled, and that the counters and alarm values hold legal BCD within each field's range. A value outside that range is compared bit for bit, but its result is not defined. The bench draws every alarm value and counter value from decimal numbers inside the field's legal range and converts them to BCD. Half the time it copies the programmed alarm value into the counter, so that matches, persistent matches and mismatches all occur often. Alarm-register writes, interrupt-enable changes and flag clears are mixed in at random between ticks.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int REG_W      = 8;
  localparam int CNT_W      = 7;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4,
    FLD_MON  = 3'd5
  } field_e;

  // BCD width of the compare value for each field index
  function automatic int field_width(input int idx);
    case (idx)
      0:       return 7;
      1:       return 7;
      2:       return 6;
      3:       return 3;
      4:       return 6;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/alm_field.sv
module alm_field #(
  parameter int VAL_W  = 7,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  output logic              en_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_byte
);
  logic             en_q;
  logic [VAL_W-1:0] val_q;

  // Enable bit: cleared by reset
  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (wr_sel) en_q <= wr_data[DATA_W-1];
  end

  // Compare value: no reset, keeps contents through reset
  always_ff @(posedge clk) begin
    if (wr_sel && !rst) val_q <= wr_data[VAL_W-1:0];
  end

  assign en_o  = en_q;
  // A disabled field never blocks the match
  assign hit_o = !en_q || (CNT_W'(val_q) == cnt);

  always_comb begin
    rd_byte               = '0;
    rd_byte[DATA_W-1]     = en_q;
    rd_byte[VAL_W-1:0]    = val_q;
  end

  assert_en_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !en_q);

  assert_value_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(val_q));
endmodule

// File: rtl/alm_event.sv
module alm_event #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [NF-1:0] en,
  input  logic [NF-1:0] hit,
  input  logic          ie_wr,
  input  logic          ie_wdata,
  input  logic          clr,
  output logic          flag_o,
  output logic          ie_o,
  output logic          irq_o
);
  logic match, set_ev, flag_nxt, ie_nxt;
  logic prev_q, flag_q, ie_q, irq_q;

  assign match    = (|en) && (&hit);
  assign set_ev   = tick && match && !prev_q;
  assign flag_nxt = set_ev || (flag_q && !clr);
  assign ie_nxt   = ie_wr ? ie_wdata : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (tick) prev_q <= match;
      flag_q <= flag_nxt;
      ie_q   <= ie_nxt;
      irq_q  <= flag_nxt && ie_nxt;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = irq_q;

  assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick));

  assert_no_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (!(|en) && !flag_q) |=> !flag_q);

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && prev_q && !flag_q) |=> !flag_q);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !tick) |=> !flag_q);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_q && ie_q));
endmodule

// File: rtl/alm_matcher.sv
module alm_matcher
  import alm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [6:0]        cnt_sec,
  input  logic [6:0]        cnt_min,
  input  logic [5:0]        cnt_hour,
  input  logic [2:0]        cnt_wday,
  input  logic [5:0]        cnt_day,
  input  logic [4:0]        cnt_mon,
  input  logic              tick,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

  logic [CNT_W-1:0]      cnt_arr  [NUM_FIELDS];
  logic [REG_W-1:0]      byte_arr [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en_vec, hit_vec;
  logic                  ctrl_wr, flag, ie;
  logic [REG_W-1:0]      rd_nxt, rd_q;

  assign cnt_arr[FLD_SEC]  = CNT_W'(cnt_sec);
  assign cnt_arr[FLD_MIN]  = CNT_W'(cnt_min);
  assign cnt_arr[FLD_HOUR] = CNT_W'(cnt_hour);
  assign cnt_arr[FLD_WDAY] = CNT_W'(cnt_wday);
  assign cnt_arr[FLD_DAY]  = CNT_W'(cnt_day);
  assign cnt_arr[FLD_MON]  = CNT_W'(cnt_mon);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int W = field_width(i);
    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(i));
    alm_field #(.VAL_W(W), .DATA_W(REG_W), .CNT_W(CNT_W)) u_field (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (sel),
      .wr_data (wr_data),
      .cnt     (cnt_arr[i]),
      .en_o    (en_vec[i]),
      .hit_o   (hit_vec[i]),
      .rd_byte (byte_arr[i])
    );
  end

  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  alm_event #(.NF(NUM_FIELDS)) u_event (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .en       (en_vec),
    .hit      (hit_vec),
    .ie_wr    (ctrl_wr),
    .ie_wdata (wr_data[0]),
    .clr      (ctrl_wr && wr_data[1]),
    .flag_o   (flag),
    .ie_o     (ie),
    .irq_o    (irq)
  );

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < NUM_FIELDS; k++)
      if (rd_addr == ADDR_W'(k)) rd_nxt = byte_arr[k];
    if (rd_addr == CTRL_ADDR) rd_nxt = {{(REG_W-2){1'b0}}, flag, ie};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  assert_spare_addr_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADDR_W'(7)) |-> (rd_data == '0));
endmodule

// File: tb/alm_matcher_bench.sv
module alm_matcher_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst = 1, wr_en = 0, tick = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [6:0] cv [6];
  logic       irq;
  int         total = 0, fails = 0;
  bit         done = 0;

  int m_en [6], m_val [6];
  int m_ie = 0, m_flag = 0, m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alm_matcher u_alm_matcher (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_sec(cv[0]), .cnt_min(cv[1]), .cnt_hour(cv[2][5:0]), .cnt_wday(cv[3][2:0]),
    .cnt_day(cv[4][5:0]), .cnt_mon(cv[5][4:0]), .tick(tick), .irq(irq)
  );

  function automatic int fw(input int i);
    case (i) 0, 1: return 7; 2, 4: return 6; 3: return 3; default: return 5; endcase
  endfunction

  function automatic int to_bcd(input int d);
    return ((d / 10) << 4) | (d % 10);
  endfunction

  function automatic int rand_bcd(input int i);
    int lo, hi;
    case (i)
      0, 1: begin lo = 0; hi = 59; end
      2:    begin lo = 0; hi = 23; end
      3:    begin lo = 0; hi = 6;  end
      4:    begin lo = 1; hi = 31; end
      default: begin lo = 1; hi = 12; end
    endcase
    return to_bcd(lo + int'($urandom % (hi - lo + 1)));
  endfunction

  function automatic int exp_byte(input int i);
    return (m_en[i] << 7) | m_val[i];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
    if (a < 6) begin
      m_en[a]  = (d >> 7) & 1;
      m_val[a] = d & ((1 << fw(a)) - 1);
    end else if (a == 6) begin
      m_ie = d & 1;
      if ((d >> 1) & 1) m_flag = 0;
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic set_match();
    for (int i = 0; i < 6; i++) cv[i] = 7'(m_val[i]);
  endtask

  // One tick; optionally a clear write in the same cycle
  task automatic do_tick(input bit clr, input string req);
    int match, any, set;
    tick = 1;
    if (clr) begin wr_en = 1; wr_addr = 3'd6; wr_data = 8'(2 | m_ie); end
    @(negedge clk);
    tick = 0; wr_en = 0;
    any = 0; match = 1;
    for (int i = 0; i < 6; i++)
      if (m_en[i] != 0) begin
        any = 1;
        if (int'(cv[i]) != m_val[i]) match = 0;
      end
    match = match & any;
    set = match & (m_prev == 0);
    m_prev = match;
    m_flag = set | (m_flag & (clr ? 0 : 1));
    chk(req, int'(irq), m_flag & m_ie);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 6; i++) m_en[i] = 0;
    m_ie = 0; m_flag = 0; m_prev = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) begin cv[i] = 0; m_en[i] = 0; m_val[i] = 0; end
    @(negedge clk);
    do_reset();

    // R2: reset state
    for (int i = 0; i < 6; i++) begin rd(i, v); chk("R2 enable clear", (v >> 7) & 1, 0); end
    rd(6, v); chk("R2 ctrl clear", v, 0);
    chk("R2 irq low", int'(irq), 0);

    // R1: program and read back
    wr(0, 'h30); wr(1, 'h15); wr(2, 'h08); wr(3, 'h03); wr(4, 'h21); wr(5, 'h06);
    for (int i = 0; i < 6; i++) begin rd(i, v); chk("R1 readback", v, exp_byte(i)); end
    wr(0, 'hD9); rd(0, v); chk("R1 sec full", v, 'hD9);
    wr(3, 'hFF); rd(3, v); chk("R1 wday pad", v, 'h87);
    wr(2, 'hFF); rd(2, v); chk("R1 hour pad", v, 'hBF);

    // R10: spare address
    wr(7, 'hFF); rd(7, v); chk("R10 spare read", v, 0);
    rd(6, v); chk("R10 ctrl untouched", v, 0);

    // R2: values survive reset
    do_reset();
    rd(0, v); chk("R2 sec kept", v, 'h59);
    rd(3, v); chk("R2 wday kept", v, 'h07);
    rd(2, v); chk("R2 hour kept", v, 'h3F);

    // R5: all equal but nothing enabled
    wr(6, 1);
    set_match(); do_tick(0, "R5 no enable");
    rd(6, v); chk("R5 flag", v, 1);

    // R9: match present without tick
    wr(0, 'hD9);
    set_match();
    repeat (3) @(negedge clk);
    chk("R9 no tick", int'(irq), 0);
    do_tick(0, "R4 match sets");
    chk("R4 irq high", int'(irq), 1);
    do_tick(0, "R7 sticky");
    wr(6, 3); chk("R7 cleared", int'(irq), 0);
    rd(6, v); chk("R7 ctrl", v, 1);
    do_tick(0, "R6 no retrigger");
    chk("R6 irq low", int'(irq), 0);
    cv[0] = 7'h01; do_tick(0, "R6 mismatch");
    set_match(); do_tick(0, "R6 rearm");
    chk("R6 rearm irq", int'(irq), 1);

    // R3: disabled fields ignored
    wr(1, 'h95); wr(6, 3);
    cv[0] = 7'h02; do_tick(0, "R3 prep");
    set_match(); cv[2] = 7'h11; cv[4] = 7'h05;
    do_tick(0, "R3 disabled ignored");
    chk("R3 irq", int'(irq), 1);

    // R7: set beats clear in the same cycle
    wr(6, 3);
    cv[0] = 7'h02; do_tick(0, "R7 prep");
    set_match(); do_tick(1, "R7 set wins");
    chk("R7 set wins irq", int'(irq), 1);

    // R8: gating by interrupt enable
    wr(6, 0); chk("R8 gated", int'(irq), 0);
    rd(6, v); chk("R8 ctrl flag only", v, 2);
    wr(6, 1); chk("R8 ungated", int'(irq), 1);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 2) begin
        int f;
        f = int'($urandom % 6);
        wr(f, (int'($urandom % 2) << 7) | rand_bcd(f));
        rd(f, v); chk("R1 random readback", v, exp_byte(f));
      end else if (r == 2) begin
        wr(6, int'($urandom % 2));
        chk("R8 random ie", int'(irq), m_flag & m_ie);
      end else begin
        for (int i = 0; i < 6; i++)
          cv[i] = ($urandom % 2) ? 7'(m_val[i]) : 7'(rand_bcd(i));
        do_tick(($urandom % 8) == 0, "R4 random tick");
        if (r == 7) begin rd(6, v); chk("R7 random flag", (v >> 1) & 1, m_flag); end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule